// File: doc/BRIEF.md
# Parcel Block Instruction Boundary Decoder

This block takes one fetched instruction block and finds where each instruction begins and how many parcels it spans. A block is a 32-bit header followed by twelve 40-bit parcels. Every instruction is one to four whole parcels long, so a boundary can only fall on one of the twelve parcel slots. The block therefore needs a small length decoder at each slot and a short chain that links them. It does not need a byte-granular cascade. An instruction may not run past the end of its block. A producer that cannot fit the last instruction moves it to the next block and pads the leftover slots.

The block sits between the instruction fetch line and the opcode decoders. Each accepted block produces one registered result. That result holds a mask of slot starts, a length per slot, and, per slot, the instruction's parcels copied out with the first parcel in the low bits. A stall input freezes the whole result. On reset the held result is the decode of an all-ones line. An all-ones parcel is the no-operation encoding, so the pipeline behind the block sees harmless instructions before the first fetch arrives.

Top module: `parcel_block_decoder`

## Requirements
- R1: After reset, out_valid is 0 and the outputs equal the decode of an all-ones line. That is start_mask = 12'h111, a length of 4 at slots 0, 4 and 8, all-ones instruction fields at those slots, and zero elsewhere.
- R2: An instruction's length in parcels equals the value of bits [1:0] of its first parcel plus one (00→1, 01→2, 10→3, 11→4). It is reported in len_out[3*s +: 3] for slot s.
- R3: Whenever out_valid is 1, start_mask[0] is 1.
- R4: A slot s > 0 is a start only if an earlier start t has a length equal to s − t. No start lies inside another instruction.
- R5: A candidate at slot s whose length L gives s + L > 12 is not a start. Its length and instruction fields read zero, and no later slot is reached through it.
- R6: For a start at slot s of length L, insn_out[160*s +: 160] holds parcels s..s+L−1, with parcel s in bits [39:0], and zero above. A slot that is not a start has a zero length and a zero instruction field.
- R7: The header bits line[31:0] have no effect on any output. Parcel p of the line is line[32+40*p +: 40].
- R8: When line_valid is 1 and stall is 0 at a rising edge, the outputs reflect that line after that edge and out_valid is 1.
- R9: While stall is 1 at a rising edge, every output keeps its value.
- R10: When line_valid is 0 and stall is 0 at a rising edge, out_valid becomes 0 and the other outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | Holds all outputs when high |
| line_valid | input | 1 | Line carries a block to decode |
| line | input | 512 | Header in bits [31:0], parcel p at 32+40*p |
| out_valid | output | 1 | Registered result belongs to an accepted block |
| start_mask | output | 12 | Bit s set when slot s starts an instruction |
| len_out | output | 36 | Three-bit length in parcels per slot, zero if not a start |
| insn_out | output | 1920 | 160-bit extracted instruction per slot, unused parcels zero |

## Verification
Every result is due exactly one rising edge after the line is presented, because the decode is combinational into a single register stage. A stall or idle edge likewise shows its effect, or its lack of one, right after that same edge. The bench changes inputs at the falling edge and samples all four outputs one nanosecond after the following rising edge. It keeps a model that advances only on those edges under the same stall and line_valid rules, so held and cleared states are compared in the cycle they occur.

// File: rtl/pbd_pkg.sv
package pbd_pkg;

  parameter int unsigned PBD_PARCEL_W = 40;
  parameter int unsigned PBD_HDR_W    = 32;
  parameter int unsigned PBD_NSLOT    = 12;
  parameter int unsigned PBD_MAXP     = 4;

  // Length in parcels encoded by the low field of a first parcel.
  function automatic int unsigned len_from_field(input int unsigned fld);
    return fld + 1;
  endfunction

  // An instruction starting at slot with len parcels stays inside the block.
  function automatic bit fits_in_block(input int unsigned slot,
                                       input int unsigned len,
                                       input int unsigned nslot);
    return (slot + len) <= nslot;
  endfunction

endpackage

// File: rtl/pbd_slot_dec.sv
module pbd_slot_dec
  import pbd_pkg::*;
#(
  parameter int unsigned SLOT  = 0,
  parameter int unsigned NSLOT = PBD_NSLOT,
  parameter int unsigned PW    = PBD_PARCEL_W,
  parameter int unsigned MAXP  = PBD_MAXP,
  localparam int unsigned LEN_W = $clog2(MAXP + 1),
  localparam int unsigned FLD_W = $clog2(MAXP),
  localparam int unsigned WIN_W = MAXP * PW
) (
  input  logic [WIN_W-1:0] win,
  input  logic             reach,
  output logic [LEN_W-1:0] raw_len,
  output logic             start,
  output logic [LEN_W-1:0] len_o,
  output logic [WIN_W-1:0] insn_o
);

  logic fits;

  assign raw_len = LEN_W'(len_from_field(32'(win[FLD_W-1:0])));
  assign fits    = fits_in_block(SLOT, 32'(raw_len), NSLOT);
  assign start   = reach & fits;
  assign len_o   = start ? raw_len : '0;

  for (genvar p = 0; p < MAXP; p++) begin : g_parcel
    assign insn_o[p*PW +: PW] =
      (start && (LEN_W'(p) < raw_len)) ? win[p*PW +: PW] : '0;
  end

endmodule

// File: rtl/pbd_decode.sv
module pbd_decode
  import pbd_pkg::*;
#(
  parameter int unsigned NSLOT = PBD_NSLOT,
  parameter int unsigned PW    = PBD_PARCEL_W,
  parameter int unsigned MAXP  = PBD_MAXP,
  localparam int unsigned LEN_W = $clog2(MAXP + 1),
  localparam int unsigned WIN_W = MAXP * PW,
  localparam int unsigned PAD_W = (NSLOT + MAXP - 1) * PW
) (
  input  logic [NSLOT*PW-1:0]    parcels,
  output logic [NSLOT-1:0]       start_mask,
  output logic [NSLOT*LEN_W-1:0] lens,
  output logic [NSLOT*WIN_W-1:0] insns
);

  logic [PAD_W-1:0] padded;
  logic [NSLOT-1:0] reach;
  logic [LEN_W-1:0] raw  [NSLOT];
  logic [MAXP-1:0]  hit  [NSLOT];

  // Zero parcels past the block end so every window slice is in range.
  assign padded = {{((MAXP-1)*PW){1'b0}}, parcels};

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    // hit[s][k-1]: the reached slot k before s ends exactly at s.
    for (genvar k = 1; k <= MAXP; k++) begin : g_back
      if (k <= s) begin : g_in
        assign hit[s][k-1] = reach[s-k] && (raw[s-k] == LEN_W'(k));
      end else begin : g_out
        assign hit[s][k-1] = 1'b0;
      end
    end

    assign reach[s] = (s == 0) ? 1'b1 : |hit[s];

    pbd_slot_dec #(
      .SLOT (s),
      .NSLOT(NSLOT),
      .PW   (PW),
      .MAXP (MAXP)
    ) u_slot (
      .win    (padded[s*PW +: WIN_W]),
      .reach  (reach[s]),
      .raw_len(raw[s]),
      .start  (start_mask[s]),
      .len_o  (lens[s*LEN_W +: LEN_W]),
      .insn_o (insns[s*WIN_W +: WIN_W])
    );
  end

endmodule

// File: rtl/pbd_hold_reg.sv
module pbd_hold_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic [W-1:0] rst_val,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= rst_val;
    else if (load) q <= d;
  end

endmodule

// File: rtl/parcel_block_decoder.sv
module parcel_block_decoder
  import pbd_pkg::*;
#(
  parameter int unsigned PARCEL_W = PBD_PARCEL_W,
  parameter int unsigned HDR_W    = PBD_HDR_W,
  parameter int unsigned NSLOT    = PBD_NSLOT,
  parameter int unsigned MAXP     = PBD_MAXP,
  localparam int unsigned LEN_W   = $clog2(MAXP + 1),
  localparam int unsigned INSN_W  = MAXP * PARCEL_W,
  localparam int unsigned BLOCK_W = HDR_W + NSLOT * PARCEL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stall,
  input  logic                    line_valid,
  input  logic [BLOCK_W-1:0]      line,
  output logic                    out_valid,
  output logic [NSLOT-1:0]        start_mask,
  output logic [NSLOT*LEN_W-1:0]  len_out,
  output logic [NSLOT*INSN_W-1:0] insn_out
);

  localparam int unsigned BODY_W = NSLOT * PARCEL_W;
  localparam int unsigned RES_W  = NSLOT + NSLOT * LEN_W + NSLOT * INSN_W;

  // Named events for the checker.
  logic cap_en;
  logic idle_en;
  assign cap_en  = !stall && line_valid;
  assign idle_en = !stall && !line_valid;

  logic unused_hdr;
  assign unused_hdr = ^line[HDR_W-1:0];

  logic [NSLOT-1:0]        live_start, boot_start;
  logic [NSLOT*LEN_W-1:0]  live_lens,  boot_lens;
  logic [NSLOT*INSN_W-1:0] live_insns, boot_insns;

  pbd_decode #(.NSLOT(NSLOT), .PW(PARCEL_W), .MAXP(MAXP)) u_dec_live (
    .parcels   (line[BLOCK_W-1:HDR_W]),
    .start_mask(live_start),
    .lens      (live_lens),
    .insns     (live_insns)
  );

  // Decode of the all-ones line held after reset; folds to a constant.
  pbd_decode #(.NSLOT(NSLOT), .PW(PARCEL_W), .MAXP(MAXP)) u_dec_boot (
    .parcels   ({BODY_W{1'b1}}),
    .start_mask(boot_start),
    .lens      (boot_lens),
    .insns     (boot_insns)
  );

  logic [RES_W-1:0] res_q;

  pbd_hold_reg #(.W(RES_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cap_en),
    .d      ({live_start, live_lens, live_insns}),
    .rst_val({boot_start, boot_lens, boot_insns}),
    .q      (res_q)
  );

  assign {start_mask, len_out, insn_out} = res_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       out_valid <= 1'b0;
    else if (cap_en)  out_valid <= 1'b1;
    else if (idle_en) out_valid <= 1'b0;
  end

endmodule

// File: rtl/pbd_checker.sv
module pbd_checker #(
  parameter int unsigned NSLOT = 12,
  parameter int unsigned MAXP  = 4,
  parameter int unsigned LEN_W = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   stall,
  input logic                   line_valid,
  input logic                   cap_en,
  input logic                   out_valid,
  input logic [NSLOT-1:0]       start_mask,
  input logic [NSLOT*LEN_W-1:0] len_out
);

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(out_valid) && $stable(start_mask) && $stable(len_out)));

  a_r3_first_slot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> start_mask[0]);

  a_r8_capture_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> out_valid);

  a_r10_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !line_valid) |=> !out_valid);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    a_r6_len_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !start_mask[s] |-> (len_out[s*LEN_W +: LEN_W] == '0));

    a_r5_fits: assert property (@(posedge clk) disable iff (!rst_n)
      start_mask[s] |-> ((s + 32'(len_out[s*LEN_W +: LEN_W])) <= NSLOT));

    for (genvar k = 1; k < MAXP; k++) begin : g_in
      if (s + k < NSLOT) begin : g_chk
        a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
          (start_mask[s] && (32'(len_out[s*LEN_W +: LEN_W]) > k))
            |-> !start_mask[s+k]);
      end
    end
  end

endmodule

bind parcel_block_decoder pbd_checker #(
  .NSLOT(NSLOT),
  .MAXP (MAXP),
  .LEN_W(LEN_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stall     (stall),
  .line_valid(line_valid),
  .cap_en    (cap_en),
  .out_valid (out_valid),
  .start_mask(start_mask),
  .len_out   (len_out)
);

// File: tb/parcel_block_decoder_bench.sv
module parcel_block_decoder_bench;

  localparam int NS = 12;
  localparam int PW = 40;
  localparam int HW = 32;
  localparam int BW = HW + NS * PW;
  localparam int IW = 4 * PW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            stall = 1'b0;
  logic            line_valid = 1'b0;
  logic [BW-1:0]   line = '0;
  logic            out_valid;
  logic [NS-1:0]   start_mask;
  logic [NS*3-1:0] len_out;
  logic [NS*IW-1:0] insn_out;

  always #5 clk = ~clk;

  parcel_block_decoder u_parcel_block_decoder (
    .clk(clk), .rst_n(rst_n), .stall(stall), .line_valid(line_valid),
    .line(line), .out_valid(out_valid), .start_mask(start_mask),
    .len_out(len_out), .insn_out(insn_out)
  );

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 1'b0;

  logic             m_valid;
  logic [NS-1:0]    m_start;
  logic [NS*3-1:0]  m_len;
  logic [NS*IW-1:0] m_insn;

  // Walk the block from slot 0, stepping by each length (R2, R4, R5, R6).
  task automatic expect_of(input logic [BW-1:0] ln,
                           output logic [NS-1:0] st,
                           output logic [NS*3-1:0] ln3,
                           output logic [NS*IW-1:0] ins);
    int pos;
    int l;
    logic [PW-1:0] p;
    st = '0; ln3 = '0; ins = '0;
    pos = 0;
    while (pos < NS) begin
      p = ln[HW + PW*pos +: PW];
      l = int'(p[1:0]) + 1;
      if (pos + l > NS) break;
      st[pos] = 1'b1;
      ln3[3*pos +: 3] = 3'(l);
      for (int j = 0; j < l; j++)
        ins[IW*pos + PW*j +: PW] = ln[HW + PW*(pos+j) +: PW];
      pos = pos + l;
    end
  endtask

  function automatic logic [BW-1:0] mk_line(input logic [23:0] flds,
                                            input logic [31:0] hdr);
    logic [BW-1:0] r;
    logic [PW-1:0] p;
    r = '0;
    r[HW-1:0] = hdr;
    for (int i = 0; i < NS; i++) begin
      p = {$urandom(), $urandom()} & {PW{1'b1}};
      p[1:0] = flds[2*i +: 2];
      r[HW + PW*i +: PW] = p;
    end
    return r;
  endfunction

  function automatic logic [BW-1:0] rnd_line();
    logic [BW-1:0] r;
    for (int i = 0; i < BW/32; i++) r[32*i +: 32] = $urandom();
    return r;
  endfunction

  task automatic compare(input string tag);
    n_checks++;
    if (out_valid !== m_valid) begin
      n_err++;
      $display("FAIL %s out_valid actual %0b expected %0b", tag, out_valid, m_valid);
    end
    n_checks++;
    if (start_mask !== m_start) begin
      n_err++;
      $display("FAIL %s/R4 start_mask actual %h expected %h", tag, start_mask, m_start);
    end
    n_checks++;
    if (len_out !== m_len) begin
      n_err++;
      $display("FAIL %s/R2 len_out actual %h expected %h", tag, len_out, m_len);
    end
    n_checks++;
    if (insn_out !== m_insn) begin
      n_err++;
      $display("FAIL %s/R6 insn_out actual %h expected %h", tag, insn_out, m_insn);
    end
  endtask

  // Drive at the falling edge, result due one rising edge later.
  task automatic step(input logic [BW-1:0] ln, input logic lv,
                      input logic st, input string tag);
    @(negedge clk);
    line = ln; line_valid = lv; stall = st;
    if (!st) begin
      if (lv) begin
        m_valid = 1'b1;
        expect_of(ln, m_start, m_len, m_insn);
      end else begin
        m_valid = 1'b0;
      end
    end
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] a;
    void'($urandom(32'd20231213));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state is the decode of an all-ones line, not valid.
    m_valid = 1'b0;
    expect_of({BW{1'b1}}, m_start, m_len, m_insn);
    #1;
    compare("R1");
    n_checks++;
    if (start_mask !== 12'h111) begin
      n_err++;
      $display("FAIL R1 start_mask actual %h expected %h", start_mask, 12'h111);
    end
    step(rnd_line(), 1'b0, 1'b0, "R1_idle_R10");

    step(mk_line(24'h000000, 32'h0), 1'b1, 1'b0, "R4_all_single");
    step(mk_line(24'hFFFFFF, 32'h1), 1'b1, 1'b0, "R2_quads_R3");
    step(mk_line(24'hAAAAAA, 32'h2), 1'b1, 1'b0, "R2_triples");
    step(mk_line(24'h555555, 32'h3), 1'b1, 1'b0, "R2_pairs");
    step(mk_line(24'h300000, 32'h4), 1'b1, 1'b0, "R5_tail_dropped");
    step(mk_line(24'hC00000, 32'h5), 1'b1, 1'b0, "R5_last_slot_long");
    step({BW{1'b1}}, 1'b1, 1'b0, "R8_all_ones");

    // R7: identical parcels under two different headers.
    a = mk_line(24'h4E1B27, 32'h0);
    step(a, 1'b1, 1'b0, "R7_hdr_a");
    a[HW-1:0] = 32'hDEADBEEF;
    step(a, 1'b1, 1'b0, "R7_hdr_b");

    // R9: stall holds everything while a different line is offered.
    step(mk_line(24'h000000, 32'h7), 1'b1, 1'b1, "R9_stall");
    step(mk_line(24'h000000, 32'h7), 1'b0, 1'b1, "R9_stall_idle");
    // R10: idle clears valid, keeps the rest.
    step(mk_line(24'hFFFFFF, 32'h8), 1'b0, 1'b0, "R10_idle");
    step(mk_line(24'h123456, 32'h9), 1'b1, 1'b0, "R8_after_idle");

    for (int i = 0; i < 400; i++) begin
      logic lv;
      logic st;
      lv = ($urandom() % 4) != 0;
      st = ($urandom() % 5) == 0;
      if (i % 2 == 0) step(rnd_line(), lv, st, "R8_random");
      else            step(mk_line(24'($urandom()), $urandom()), lv, st, "R4_random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

endmodule